// File: doc/BRIEF.md
# QPSK Carrier Recovery Loop

This block locks a local carrier to an incoming QPSK intermediate-frequency signal whose carrier is close to, but not exactly at, a quarter of the sample rate. A direct digital synthesizer produces an in-phase and a quadrature local oscillator. These oscillators mix each received sample down to baseband. Two accumulators then sum the mixer products over the eight samples of each symbol and release one soft symbol pair per symbol.

The sign of each soft value gives the hard decision. The soft values and their decisions together form a decision-directed phase error. A proportional-integral filter turns this error into a correction of the synthesizer's frequency word. The proportional path produces a short frequency kick, which acts as a phase step, and the integral path tracks a steady frequency offset. Both gains are arithmetic right shifts that can be changed while the loop runs.

Symbol boundaries come from a free-running sample counter. After lock, the constellation may sit at any of four rotations that are multiples of 90 degrees. This block does not resolve that rotation, and it does not perform symbol timing recovery.

Top module: `qpsk_carrier_loop`

## Requirements
- R1: While the synchronous active-high `rst` is sampled high, the block clears the phase accumulator, the integrator, the loop correction and the symbol counter. During and after reset, `sym_i`, `sym_q`, `bit_i`, `bit_q` and `sym_stb` read 0, and `nco_step` equals the nominal word 0x40000000. The first sample after release is the first sample of a symbol.
- R2: `sym_stb` is high for exactly one cycle after every eighth sample. The first pulse appears after the eighth rising edge that follows reset release.
- R3: For each symbol, the block forms eight in-phase products (rx·lo_c)>>>11 and eight quadrature products (rx·lo_q)>>>11. Each sum is shifted arithmetically right by 2 and clamped to [-2048, 2047]. The results appear on `sym_i` and `sym_q` together with `sym_stb` and hold until the next pulse.
- R4: `bit_i` is 1 exactly when `sym_i` is negative, and 0 when it is zero or positive. `bit_q` follows `sym_q` in the same way.
- R5: The 32-bit phase accumulator adds `nco_step` on every rising edge. The oscillator values use the accumulator value before the add. Bits 31:30 select the quadrant and bits 29:22 select the index k. The table value is T[k] = floor(2047·4p·(1024−p)/1048576) with p = 2k+1, and ~k denotes 255−k. The pair (lo_c, lo_q) is (T[~k], −T[k]) in quadrant 0, (−T[k], −T[~k]) in quadrant 1, (−T[~k], T[k]) in quadrant 2 and (T[k], T[~k]) in quadrant 3.
- R6: The phase error is e = sym_q·s(sym_i) − sym_i·s(sym_q), where s(v) = +1 for v ≥ 0 and −1 otherwise. On each cycle with `sym_stb` high, the integrator becomes clamp(integ + (e·2^20)>>>ki_shift). The correction then becomes clamp(new integ + (e·2^20)>>>kp_shift). On all other cycles the correction holds.
- R7: `nco_step` equals 0x40000000 plus the signed correction, modulo 2^32. A change of `kp_shift` or `ki_shift` takes effect at the next strobe without a reset.
- R8: The integrator and the correction clamp at −2^31 and 2^31−1 instead of wrapping.
- R9: Consider a carrier at exactly a quarter of the sample rate, in phase with the oscillator at reset release, with both shifts at 40. The input is x = A(I·cos − Q·sin), where a transmitted bit of 1 means a component of −1. Under these conditions each strobe shows the transmitted bit pair of the symbol that has just ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_in | input | 12 | Received IF sample, signed, 11 fractional bits |
| kp_shift | input | 6 | Proportional gain as a right-shift amount |
| ki_shift | input | 6 | Integral gain as a right-shift amount |
| sym_i | output | 12 | In-phase soft symbol, signed, 11 fractional bits |
| sym_q | output | 12 | Quadrature soft symbol, signed, 11 fractional bits |
| bit_i | output | 1 | In-phase hard decision (1 = negative) |
| bit_q | output | 1 | Quadrature hard decision (1 = negative) |
| sym_stb | output | 1 | One-cycle pulse when a new symbol pair is valid |
| nco_step | output | 32 | Synthesizer frequency word in use |

## Verification
The hardest state to reach from the ports is a clamped integrator. A carrier near a quarter of the sample rate with moderate gains never pushes the integrator anywhere near its limits. The stimulus therefore applies a carrier offset of one percent of the sample rate with both shifts at zero. In this setting each symbol's error moves the integrator by up to 2^32, so the integrator hits both limits within a few symbols. The behavioural reference model records each clamp event, and a cycle-by-cycle comparison of `nco_step` confirms that the frequency word stays pinned at the limit rather than wrapping.

// File: rtl/qpsk_carrier_loop.sv
module qpsk_carrier_loop #(
  parameter int SW  = 12,
  parameter int SPS = 8,
  parameter int PW  = 32,
  parameter int LAW = 8,
  parameter logic [PW-1:0] NOM = 32'h4000_0000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [SW-1:0] rx_in,
  input  logic [5:0]           kp_shift,
  input  logic [5:0]           ki_shift,
  output logic signed [SW-1:0] sym_i,
  output logic signed [SW-1:0] sym_q,
  output logic                 bit_i,
  output logic                 bit_q,
  output logic                 sym_stb,
  output logic [PW-1:0]        nco_step
);

  localparam int NQ  = 1 << LAW;
  localparam int CW  = $clog2(SPS);
  localparam int MW  = SW + 1;
  localparam int ACW = MW + CW;
  localparam int EW  = SW + 2;
  localparam int FSH = PW - SW;
  localparam int XW  = EW + FSH;
  localparam int ZW  = XW + 2;
  localparam int AMP = (1 << (SW - 1)) - 1;
  localparam longint HP = 4 * NQ;
  localparam logic signed [ZW-1:0] PMAX = ZW'((64'sd1 <<< (PW - 1)) - 1);
  localparam logic signed [ZW-1:0] PMIN = ZW'(-(64'sd1 <<< (PW - 1)));

  function automatic logic signed [SW-1:0] qwave(int k);
    longint p;
    p = 2 * k + 1;
    return SW'((longint'(AMP) * 4 * p * (HP - p)) / (HP * HP));
  endfunction

  function automatic logic signed [SW-1:0] sat_sym(logic signed [ACW-1:0] v);
    int t;
    t = int'(v >>> (CW - 1));
    if (t > AMP) return SW'(AMP);
    if (t < -AMP - 1) return SW'(-AMP - 1);
    return SW'(t);
  endfunction

  function automatic logic signed [PW-1:0] sat_pw(logic signed [ZW-1:0] v);
    if (v > PMAX) return {1'b0, {(PW-1){1'b1}}};
    if (v < PMIN) return {1'b1, {(PW-1){1'b0}}};
    return v[PW-1:0];
  endfunction

  function automatic logic signed [EW-1:0] perr_of(logic signed [SW-1:0] a,
                                                    logic signed [SW-1:0] b);
    logic signed [EW-1:0] qa, ib;
    qa = a[SW-1] ? -EW'(b) : EW'(b);
    ib = b[SW-1] ? -EW'(a) : EW'(a);
    return qa - ib;
  endfunction

  logic signed [SW-1:0] lut [NQ];
  for (genvar k = 0; k < NQ; k++) begin : g_lut
    assign lut[k] = qwave(k);
  end

  logic [PW-1:0]  ph;
  logic [1:0]     quad;
  logic [LAW-1:0] idx, ridx;
  logic signed [SW-1:0] lo_c, lo_q;

  assign quad = ph[PW-1 -: 2];
  assign idx  = ph[PW-3 -: LAW];
  assign ridx = ~idx;

  always_comb begin
    case (quad)
      2'd0:    begin lo_c =  lut[ridx]; lo_q = -lut[idx];  end
      2'd1:    begin lo_c = -lut[idx];  lo_q = -lut[ridx]; end
      2'd2:    begin lo_c = -lut[ridx]; lo_q =  lut[idx];  end
      default: begin lo_c =  lut[idx];  lo_q =  lut[ridx]; end
    endcase
  end

  logic signed [2*SW-1:0] pr_i, pr_q;
  logic signed [MW-1:0]   mix_i, mix_q;
  assign pr_i  = (2*SW)'(rx_in) * (2*SW)'(lo_c);
  assign pr_q  = (2*SW)'(rx_in) * (2*SW)'(lo_q);
  assign mix_i = MW'(pr_i >>> (SW - 1));
  assign mix_q = MW'(pr_q >>> (SW - 1));

  logic [CW-1:0] cnt;
  logic          last;
  logic signed [ACW-1:0] acc_i, acc_q, base_i, base_q, sum_i, sum_q;
  logic signed [SW-1:0]  nsi, nsq;

  assign last   = (cnt == CW'(SPS - 1));
  assign base_i = (cnt == '0) ? '0 : acc_i;
  assign base_q = (cnt == '0) ? '0 : acc_q;
  assign sum_i  = base_i + mix_i;
  assign sum_q  = base_q + mix_q;
  assign nsi    = sat_sym(sum_i);
  assign nsq    = sat_sym(sum_q);

  logic signed [EW-1:0] perr;
  logic signed [PW-1:0] integ, lf, integ_n, lf_n;
  logic signed [XW-1:0] ex, pt, it;
  logic signed [ZW-1:0] isum, psum;

  assign ex      = {perr, {FSH{1'b0}}};
  assign pt      = ex >>> kp_shift;
  assign it      = ex >>> ki_shift;
  assign isum    = ZW'(integ) + ZW'(it);
  assign integ_n = sat_pw(isum);
  assign psum    = ZW'(integ_n) + ZW'(pt);
  assign lf_n    = sat_pw(psum);

  assign nco_step = NOM + lf;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= '0;
      cnt     <= '0;
      acc_i   <= '0;
      acc_q   <= '0;
      sym_i   <= '0;
      sym_q   <= '0;
      bit_i   <= 1'b0;
      bit_q   <= 1'b0;
      sym_stb <= 1'b0;
      perr    <= '0;
      integ   <= '0;
      lf      <= '0;
    end else begin
      ph      <= ph + nco_step;
      cnt     <= last ? '0 : cnt + 1'b1;
      acc_i   <= sum_i;
      acc_q   <= sum_q;
      sym_stb <= last;
      if (last) begin
        sym_i <= nsi;
        sym_q <= nsq;
        bit_i <= nsi[SW-1];
        bit_q <= nsq[SW-1];
        perr  <= perr_of(nsi, nsq);
      end
      if (sym_stb) begin
        integ <= integ_n;
        lf    <= lf_n;
      end
    end
  end

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst) sym_stb |=> !sym_stb); // R2
  AST_SYM_HOLD: assert property (@(posedge clk) disable iff (rst) (!sym_stb && !$past(rst)) |-> ($stable(sym_i) && $stable(sym_q))); // R3
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst) !sym_stb |=> $stable(lf)); // R6
  AST_INTEG_UP: assert property (@(posedge clk) disable iff (rst) (sym_stb && perr > 0) |=> integ >= $past(integ)); // R8
  AST_INTEG_DOWN: assert property (@(posedge clk) disable iff (rst) (sym_stb && perr < 0) |=> integ <= $past(integ)); // R8

endmodule

// File: tb/sim_qpsk_carrier_loop.sv
module sim_qpsk_carrier_loop;
  localparam longint NOMV = 64'h4000_0000;
  localparam longint MASK = 64'hFFFF_FFFF;
  localparam longint SMAX = 64'sd2147483647;
  localparam longint SMIN = -64'sd2147483648;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst = 1'b1;
  logic signed [11:0] rx_in = '0;
  logic [5:0]        kp_shift = 6'd40, ki_shift = 6'd40;
  logic signed [11:0] sym_i, sym_q;
  logic              bit_i, bit_q, sym_stb;
  logic [31:0]       nco_step;

  qpsk_carrier_loop u0 (
    .clk(clk), .rst(rst), .rx_in(rx_in), .kp_shift(kp_shift), .ki_shift(ki_shift),
    .sym_i(sym_i), .sym_q(sym_q), .bit_i(bit_i), .bit_q(bit_q),
    .sym_stb(sym_stb), .nco_step(nco_step)
  );

  int total = 0, bad = 0, sat_hits = 0;
  bit cmp_en = 0, chk_r9 = 0;
  real df = 0.0, phi = 0.0, amp = 0.6;
  int n = 0;
  bit txb_i [8192];
  bit txb_q [8192];

  longint m_ph, m_acc_i, m_acc_q, m_si, m_sq, m_perr, m_integ, m_lf;
  int m_cnt, m_nsym;
  bit m_stb;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint asr(longint v, int s);
    return v >>> s;
  endfunction

  function automatic longint wave(longint k);
    longint p;
    p = 2 * k + 1;
    return (2047 * 4 * p * (1024 - p)) / 1048576;
  endfunction

  function automatic longint clamp(longint v, longint lo, longint hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic longint sgnmul(longint v, longint ref_v);
    return (ref_v >= 0) ? v : -v;
  endfunction

  always @(posedge clk) begin : model
    longint x, k, r, c, qv, si, sq, step, it, pt, ni;
    int quad;
    if (rst) begin
      m_ph = 0; m_acc_i = 0; m_acc_q = 0; m_si = 0; m_sq = 0;
      m_perr = 0; m_integ = 0; m_lf = 0; m_cnt = 0; m_nsym = 0; m_stb = 0;
    end else begin
      x = longint'(rx_in);
      quad = int'((m_ph >> 30) & 3);
      k = (m_ph >> 22) & 255;
      r = 255 - k;
      case (quad)
        0: begin c =  wave(r); qv = -wave(k); end
        1: begin c = -wave(k); qv = -wave(r); end
        2: begin c = -wave(r); qv =  wave(k); end
        default: begin c = wave(k); qv = wave(r); end
      endcase
      si = ((m_cnt == 0) ? 0 : m_acc_i) + asr(x * c, 11);
      sq = ((m_cnt == 0) ? 0 : m_acc_q) + asr(x * qv, 11);
      step = (NOMV + m_lf) & MASK;
      if (m_stb) begin
        it = asr(m_perr * 1048576, int'(ki_shift));
        pt = asr(m_perr * 1048576, int'(kp_shift));
        ni = clamp(m_integ + it, SMIN, SMAX);
        if (ni == SMIN || ni == SMAX) sat_hits++;
        m_lf = clamp(ni + pt, SMIN, SMAX);
        m_integ = ni;
      end
      m_ph = (m_ph + step) & MASK;
      if (m_cnt == 7) begin
        m_si = clamp(asr(si, 2), -2048, 2047);
        m_sq = clamp(asr(sq, 2), -2048, 2047);
        m_perr = sgnmul(m_sq, m_si) - sgnmul(m_si, m_sq);
        m_stb = 1;
        m_nsym++;
      end else begin
        m_stb = 0;
      end
      m_acc_i = si;
      m_acc_q = sq;
      m_cnt = (m_cnt + 1) % 8;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(longint'(sym_i) == m_si, "R3/R5", "sym_i", longint'(sym_i), m_si);
      chk(longint'(sym_q) == m_sq, "R3/R5", "sym_q", longint'(sym_q), m_sq);
      chk(bit_i == (m_si < 0) && bit_q == (m_sq < 0), "R4", "bit pair",
          {bit_i, bit_q}, {m_si < 0, m_sq < 0});
      chk(sym_stb == m_stb, "R2", "sym_stb", sym_stb, m_stb);
      chk(longint'(nco_step) == ((NOMV + m_lf) & MASK), "R6/R7", "nco_step",
          longint'(nco_step), (NOMV + m_lf) & MASK);
      if (chk_r9 && sym_stb) begin
        chk(bit_i == txb_i[(m_nsym - 1) % 8192] && bit_q == txb_q[(m_nsym - 1) % 8192],
            "R9", "decided bits", {bit_i, bit_q},
            {txb_i[(m_nsym - 1) % 8192], txb_q[(m_nsym - 1) % 8192]});
      end
    end
  end

  task automatic drive_sample();
    real ang, vi, vq, xv;
    int xi, s;
    s = (n / 8) % 8192;
    if (n % 8 == 0) begin
      txb_i[s] = 1'($urandom_range(0, 1));
      txb_q[s] = 1'($urandom_range(0, 1));
    end
    vi = txb_i[s] ? -1.0 : 1.0;
    vq = txb_q[s] ? -1.0 : 1.0;
    ang = 2.0 * 3.14159265358979 * (0.25 + df) * n + phi;
    xv = amp * 2047.0 * (vi * $cos(ang) - vq * $sin(ang));
    xi = int'(xv);
    if (xi > 2047) xi = 2047;
    if (xi < -2048) xi = -2048;
    rx_in = 12'(xi);
    n++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    rx_in = '0;
    repeat (3) @(negedge clk);
    chk(sym_i == 0 && sym_q == 0, "R1", "soft in reset", {sym_i, sym_q}, 0);
    chk(bit_i == 0 && bit_q == 0 && sym_stb == 0, "R1", "flags in reset",
        {bit_i, bit_q, sym_stb}, 0);
    chk(longint'(nco_step) == NOMV, "R1", "step in reset", longint'(nco_step), NOMV);
    cmp_en = 1'b1;
    rst = 1'b0;
    n = 0;
    drive_sample();
  endtask

  task automatic run(int cycles);
    repeat (cycles) begin
      @(negedge clk);
      drive_sample();
    end
  endtask

  initial begin
    df = 0.0; phi = 0.0; amp = 0.6;
    kp_shift = 6'd40; ki_shift = 6'd40;
    chk_r9 = 1'b1;
    do_reset();
    run(2000);
    chk_r9 = 1'b0;

    df = 2.0e-5; phi = 0.3; kp_shift = 6'd12; ki_shift = 6'd20;
    do_reset();
    run(8000);

    df = 0.01; phi = 1.0; amp = 0.9; kp_shift = 6'd0; ki_shift = 6'd0;
    sat_hits = 0;
    do_reset();
    run(3000);
    chk(sat_hits > 0, "R8", "clamp events seen", sat_hits, 1);

    df = -2.0e-5; phi = -0.2; amp = 0.6; kp_shift = 6'd10; ki_shift = 6'd18;
    do_reset();
    run(4000);
    kp_shift = 6'd8; ki_shift = 6'd16;
    run(4000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL R2 watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule